// File: doc/BRIEF.md
# Carry-Select Adder

A purely combinational adder that splits its operands into equal 4-bit slices. The least significant slice is summed directly with the external carry-in. Every slice above it holds two complete sums built side by side: one assumes an incoming carry of 0 and the other assumes 1. When the carry from the slice below settles, a bank of 2-to-1 selectors keeps the matching copy. The result is that a high slice does not have to wait for the carry to ripple through it.

The default build is 8 bits wide, made of two slices. A parameter sets the number of slices, and each extra slice takes its select from the carry chosen by the slice beneath it. Inside each slice there is a plain ripple-carry adder.

Top module: `carry_select_adder`

## Requirements
- R1: `sum_o[3:0]` equals the low four bits of `a_i[3:0] + b_i[3:0] + cin_i`.
- R2: When the low slice produces no carry (`a_i[3:0] + b_i[3:0] + cin_i` < 16), `sum_o[7:4]` equals `a_i[7:4] + b_i[7:4]` modulo 16.
- R3: When the low slice produces a carry (that sum is 16 or more), `sum_o[7:4]` equals `a_i[7:4] + b_i[7:4] + 1` modulo 16.
- R4: `cout_o` is 1 exactly when `a_i + b_i + cin_i` is greater than 2^WIDTH - 1.
- R5: For every operand pair and both carry-in values, `{cout_o, sum_o}` equals `a_i + b_i + cin_i`. Each slice's carry-1 copy is always its carry-0 copy plus one.
- R6: A carry entering the bottom slice propagates through every selected slice. Example: `a_i` = all ones, `b_i` = 0, `cin_i` = 1 gives `sum_o` = 0 and `cout_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH (8) | First operand |
| b_i | input | WIDTH (8) | Second operand |
| cin_i | input | 1 | Carry into the least significant slice |
| sum_o | output | WIDTH (8) | Sum bits |
| cout_o | output | 1 | Carry out of the most significant slice |

## Verification
The bench builds the adder with its default parameters: two slices of 4 bits, which makes an 8-bit adder. At that width every combination of the two operands and both carry-in values can be applied, 131072 vectors in total. This covers every select decision in the upper slice and every carry path that runs the full length of the chain. A short directed pass runs first and targets the wrap-around and full-propagation corners by name.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned SLICE_W_DEF = 4;
  localparam int unsigned N_SLICE_DEF = 2;
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] c;
  assign c[0] = ci_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = a_i[i] ^ b_i[i];
    assign s_o[i]   = p ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & p);
  end

  assign co_o = c[W];

  // R5: slice result matches its arithmetic sum
  always_comb begin
    if (!$isunknown({a_i, b_i, ci_i}))
      a_r5_slice_sum: assert ({co_o, s_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i}));
  end
endmodule

// File: rtl/csa_select_slice.sv
module csa_select_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W-1:0] s_c0, s_c1;
  logic         co_c0, co_c1;
  logic [W:0]   r_c0, r_c1, r_sel;

  csa_ripple #(.W(W)) u_c0 (
    .a_i(a_i), .b_i(b_i), .ci_i(1'b0), .s_o(s_c0), .co_o(co_c0)
  );
  csa_ripple #(.W(W)) u_c1 (
    .a_i(a_i), .b_i(b_i), .ci_i(1'b1), .s_o(s_c1), .co_o(co_c1)
  );

  assign r_c0 = {co_c0, s_c0};
  assign r_c1 = {co_c1, s_c1};

  // W+1 two-input selectors, one per sum bit plus carry
  for (genvar j = 0; j <= W; j++) begin : g_mux
    assign r_sel[j] = sel_i ? r_c1[j] : r_c0[j];
  end

  assign s_o  = r_sel[W-1:0];
  assign co_o = r_sel[W];

  // R5: the two speculative copies differ by exactly one
  always_comb begin
    if (!$isunknown({a_i, b_i}))
      a_r5_copy_offset: assert (r_c1 == r_c0 + {{W{1'b0}}, 1'b1});
  end
endmodule

// File: rtl/carry_select_adder.sv
module carry_select_adder
  import csa_pkg::*;
#(
  parameter int unsigned SLICE_W = SLICE_W_DEF,
  parameter int unsigned N_SLICE = N_SLICE_DEF,
  localparam int unsigned WIDTH  = SLICE_W * N_SLICE
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [N_SLICE:0] carry;

  csa_ripple #(.W(SLICE_W)) u_low (
    .a_i (a_i[SLICE_W-1:0]),
    .b_i (b_i[SLICE_W-1:0]),
    .ci_i(cin_i),
    .s_o (sum_o[SLICE_W-1:0]),
    .co_o(carry[1])
  );
  assign carry[0] = cin_i;

  // each upper slice selects on the carry picked by the slice below
  for (genvar k = 1; k < N_SLICE; k++) begin : g_slice
    csa_select_slice #(.W(SLICE_W)) u_sel (
      .a_i  (a_i[k*SLICE_W +: SLICE_W]),
      .b_i  (b_i[k*SLICE_W +: SLICE_W]),
      .sel_i(carry[k]),
      .s_o  (sum_o[k*SLICE_W +: SLICE_W]),
      .co_o (carry[k+1])
    );
  end

  assign cout_o = carry[N_SLICE];

  logic [SLICE_W:0] low_ref;
  logic [WIDTH:0]   full_ref;
  assign low_ref  = {1'b0, a_i[SLICE_W-1:0]} + {1'b0, b_i[SLICE_W-1:0]}
                  + {{SLICE_W{1'b0}}, cin_i};
  assign full_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      a_r1_low_slice: assert (sum_o[SLICE_W-1:0] == low_ref[SLICE_W-1:0]);
      a_r4_carry_out: assert (cout_o == full_ref[WIDTH]);
      a_r5_full_sum:  assert ({cout_o, sum_o} == full_ref);
    end
  end
endmodule

// File: tb/carry_select_adder_test.sv
module carry_select_adder_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #5 clk = ~clk;

  carry_select_adder uut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  task automatic apply(input int av, input int bv, input int cv, input string tag);
    int exp_full, exp_lo, exp_hi, exp_co, low_raw;
    string req;
    @(posedge clk);
    a   = av[W-1:0];
    b   = bv[W-1:0];
    cin = cv[0];
    @(negedge clk);
    exp_full = av + bv + cv;
    low_raw  = (av % 16) + (bv % 16) + cv;
    exp_lo   = exp_full % 16;
    exp_hi   = (exp_full / 16) % 16;
    exp_co   = exp_full / 256;
    n_cmp++;
    if (sum[3:0] != exp_lo[3:0]) req = "R1";
    else if (sum[7:4] != exp_hi[3:0]) req = (low_raw > 15) ? "R3" : "R2";
    else if (cout != exp_co[0]) req = "R4";
    else req = "";
    if (req != "") begin
      n_bad++;
      $display("FAIL %s/R5 %s a=%0d b=%0d cin=%0d: got %0d expected %0d",
               req, tag, av, bv, cv, {cout, sum}, exp_full);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    // directed corners
    apply(0,   0,   0, "zero");            // R1 R4
    apply(255, 0,   1, "R6 full carry");   // R6: sum 0, cout 1
    apply(255, 255, 1, "R4 max");          // 511
    apply(15,  0,   1, "R3 low carry");    // C4=1
    apply(14,  0,   1, "R2 no low carry"); // C4=0
    apply(128, 128, 0, "R4 top wrap");
    // exhaustive sweep, R5
    for (int ci = 0; ci < 2; ci++)
      for (int ai = 0; ai < 256; ai++)
        for (int bi = 0; bi < 256; bi++)
          apply(ai, bi, ci, "sweep");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (140000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule